// File: doc/BRIEF.md
# Reload-Compare PWM Timer

This block produces a pulse-width-modulated output from a free-running up-counter whose period and duty are set as offsets below the counter's all-ones ceiling. Once running, the counter climbs from a programmed reload value to the ceiling. On the next clock it wraps back to the reload value. The output is in its active phase from the reload value up to and including the compare value. It is inactive from the cycle after the compare match until the wrap.

Software converts its wanted period and duty into clock counts. It programs the reload value as ceiling minus period plus one, and the compare value as reload plus duty minus one. This is done through a small synchronous write port while the timer is stopped. A control bit starts and stops the counter, and a second bit selects active-low output. A status output reports whether the counter is running, and a single-cycle pulse marks each wrap.

Top module: `reload_pwm_timer`

## Requirements
- R1: After reset the timer is stopped, the output is low, the wrap pulse is low, the count reads 0, and both reload and compare read 0xFFFFFFFE.
- R2: A write to address 0 with bit 0 set while stopped starts the timer. In the next cycle the count holds the reload value and the running status is high.
- R3: While running, the count increments each cycle. In the cycle after it holds 0xFFFFFFFF it holds the reload value again, so one period lasts (0xFFFFFFFF − reload + 1) cycles.
- R4: While running, the output is active for (compare − reload + 1) cycles, starting in the cycle the count holds reload. It is inactive for the remaining (0xFFFFFFFF − compare) cycles. With reload 0xFFFFFFFC and compare 0xFFFFFFFD the output repeats 2 active and 2 inactive cycles, a 4-cycle period.
- R5: The wrap pulse is high for exactly the one cycle in which the count holds the reload value after a wrap from 0xFFFFFFFF. It is not raised on start.
- R6: Writes to reload (address 1) or compare (address 2) while running are ignored, and the old values still read back.
- R7: A reload write above 0xFFFFFFFE or above the current compare value is rejected. A compare write below the current reload value is rejected. The previous value is kept in both cases.
- R8: A write to address 0 with bit 0 clear stops the timer. From the next cycle the running status is low, the count holds its value, and the output sits at its inactive level.
- R9: Bit 1 of address 0 selects polarity: 0 is active-high, 1 is active-low. In active-low mode the output is high while stopped and during the inactive phase.
- R10: Reads are combinational on the read port. Address 0 returns {invert, run} in bits 1:0, address 1 returns reload, address 2 returns compare, and address 3 returns the live count. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 32 | Read data |
| running | output | 1 | Timer running status |
| pwmOut | output | 1 | PWM output |
| wrapPulse | output | 1 | One-cycle pulse on counter wrap |

## Verification
On every cycle, the assertions check the following:
- a count at the ceiling is always followed by the wrap pulse with the reload value in the counter;
- the configuration stays frozen while running and always stays legal;
- a stopped timer holds its count and drives the inactive level;
- the count never falls below reload while running.

Only the bench scenarios can show the exact waveforms. These include the 2-high/2-low pattern for the 4-cycle setting, the alternating minimum period, the always-active compare-at-ceiling case and inverted polarity. They also show that rejected writes leave the old value in the readable registers.

// File: rtl/reload_pwm_pkg.sv
package reload_pwm_pkg;
  localparam int unsigned CNT_W = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL    = 2'd0,
    ADDR_RELOAD  = 2'd1,
    ADDR_COMPARE = 2'd2,
    ADDR_COUNT   = 2'd3
  } regAddr_t;

  typedef struct packed {
    logic startLoad;  // load counter with reload value
    logic advance;    // counter steps this cycle
    logic running;    // timer enabled
    logic invert;     // active-low output
  } ctrlStrobes_t;
endpackage

// File: rtl/reload_pwm_ctrl.sv
module reload_pwm_ctrl
  import reload_pwm_pkg::*;
#(
  parameter int unsigned WIDTH = CNT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [WIDTH-1:0]     wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [WIDTH-1:0]     countVal,
  output logic [WIDTH-1:0]     rdData,
  output logic [WIDTH-1:0]     reloadVal,
  output logic [WIDTH-1:0]     compareVal,
  output ctrlStrobes_t         strobes
);
  localparam logic [WIDTH-1:0] CEIL       = '1;
  localparam logic [WIDTH-1:0] RELOAD_MAX = CEIL - 1'b1;

  logic runQ, invertQ;
  logic [WIDTH-1:0] reloadQ, compareQ;
  logic ctrlWr, reloadWr, compareWr;
  logic reloadOk, compareOk;

  assign ctrlWr    = wrEn && (regAddr_t'(wrAddr) == ADDR_CTRL);
  assign reloadWr  = wrEn && (regAddr_t'(wrAddr) == ADDR_RELOAD);
  assign compareWr = wrEn && (regAddr_t'(wrAddr) == ADDR_COMPARE);

  // Configuration is accepted only while stopped and only if it keeps
  // reload <= compare and reload below the ceiling.
  assign reloadOk  = !runQ && (wrData <= RELOAD_MAX) && (wrData <= compareQ);
  assign compareOk = !runQ && (wrData >= reloadQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      invertQ  <= 1'b0;
      reloadQ  <= RELOAD_MAX;
      compareQ <= RELOAD_MAX;
    end else begin
      if (ctrlWr) begin
        runQ    <= wrData[0];
        invertQ <= wrData[1];
      end
      if (reloadWr && reloadOk)   reloadQ  <= wrData;
      if (compareWr && compareOk) compareQ <= wrData;
    end
  end

  always_comb begin
    strobes.startLoad = ctrlWr && wrData[0] && !runQ;
    strobes.advance   = runQ;
    strobes.running   = runQ;
    strobes.invert    = invertQ;
  end

  always_comb begin
    unique case (regAddr_t'(rdAddr))
      ADDR_CTRL:    rdData = {{(WIDTH-2){1'b0}}, invertQ, runQ};
      ADDR_RELOAD:  rdData = reloadQ;
      ADDR_COMPARE: rdData = compareQ;
      ADDR_COUNT:   rdData = countVal;
      default:      rdData = '0;
    endcase
  end

  assign reloadVal  = reloadQ;
  assign compareVal = compareQ;
endmodule

// File: rtl/reload_pwm_datapath.sv
module reload_pwm_datapath
  import reload_pwm_pkg::*;
#(
  parameter int unsigned WIDTH = CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WIDTH-1:0]  reloadVal,
  input  logic [WIDTH-1:0]  compareVal,
  output logic [WIDTH-1:0]  countVal,
  output logic              pwmOut,
  output logic              wrapPulse
);
  localparam logic [WIDTH-1:0] CEIL = '1;

  logic [WIDTH-1:0] countQ;
  logic wrapQ;
  logic atCeil, activePhase;

  assign atCeil = (countQ == CEIL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      wrapQ  <= 1'b0;
    end else if (strobes.startLoad) begin
      countQ <= reloadVal;
      wrapQ  <= 1'b0;
    end else if (strobes.advance) begin
      if (atCeil) begin
        countQ <= reloadVal;
        wrapQ  <= 1'b1;
      end else begin
        countQ <= countQ + 1'b1;
        wrapQ  <= 1'b0;
      end
    end else begin
      wrapQ <= 1'b0;
    end
  end

  // Count never goes below reload while running, so only the upper
  // bound decides the phase.
  assign activePhase = strobes.running && (countQ <= compareVal);
  assign pwmOut      = activePhase ^ strobes.invert;
  assign countVal    = countQ;
  assign wrapPulse   = wrapQ;
endmodule

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer
  import reload_pwm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [CNT_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [CNT_W-1:0]   rdData,
  output logic               running,
  output logic               pwmOut,
  output logic               wrapPulse
);
  ctrlStrobes_t strobes;
  logic [CNT_W-1:0] reloadVal, compareVal, countVal;
  logic invertLvl;

  reload_pwm_ctrl #(.WIDTH(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .countVal(countVal), .rdData(rdData),
    .reloadVal(reloadVal), .compareVal(compareVal), .strobes(strobes)
  );

  reload_pwm_datapath #(.WIDTH(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reloadVal(reloadVal),
    .compareVal(compareVal), .countVal(countVal), .pwmOut(pwmOut),
    .wrapPulse(wrapPulse)
  );

  assign running   = strobes.running;
  assign invertLvl = strobes.invert;
endmodule

// File: rtl/reload_pwm_checker.sv
module reload_pwm_checker
  import reload_pwm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [CNT_W-1:0]  wrData,
  input logic              running,
  input logic              pwmOut,
  input logic              wrapPulse,
  input logic              invertLvl,
  input logic [CNT_W-1:0]  countVal,
  input logic [CNT_W-1:0]  reloadVal,
  input logic [CNT_W-1:0]  compareVal
);
  localparam logic [CNT_W-1:0] CEIL = '1;
  logic startWr;
  assign startWr = wrEn && (wrAddr == 2'd0) && wrData[0];

  assert_wrap_on_ceiling_R3: assert property (@(posedge clk) disable iff (!rstN)
    (running && countVal == CEIL) |=> (wrapPulse && countVal == reloadVal));

  assert_wrap_at_reload_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> (countVal == reloadVal));

  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (countVal >= reloadVal));

  assert_config_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    running |=> ($stable(reloadVal) && $stable(compareVal)));

  assert_config_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reloadVal <= CEIL - 1'b1) && (reloadVal <= compareVal));

  assert_stopped_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !startWr) |=> $stable(countVal));

  assert_stopped_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (pwmOut == invertLvl));
endmodule

bind reload_pwm_timer reload_pwm_checker u_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .running(running), .pwmOut(pwmOut), .wrapPulse(wrapPulse),
  .invertLvl(invertLvl), .countVal(countVal), .reloadVal(reloadVal),
  .compareVal(compareVal)
);

// File: tb/test_reload_pwm_timer.sv
`timescale 1ns/1ps
module test_reload_pwm_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [31:0] rdData;
  logic running, pwmOut, wrapPulse;

  int nTests = 0;
  int nFail = 0;

  always #2 clk = ~clk;  // 250 MHz

  reload_pwm_timer i_reload_pwm_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .running(running), .pwmOut(pwmOut),
    .wrapPulse(wrapPulse)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive at negedge, commit on posedge, return at next negedge.
  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic configure(input logic [31:0] rl, input logic [31:0] cp);
    writeReg(2'd0, 32'd0);
    writeReg(2'd2, 32'hFFFF_FFFF);
    writeReg(2'd1, rl);
    writeReg(2'd2, cp);
  endtask

  // Start and compare every cycle to the period/duty model.
  task automatic runPattern(input logic [31:0] rl, input logic [31:0] cp,
                            input logic inv, input int cycles, input string req);
    logic [31:0] period, phase, expCount, rd;
    int actives = 0;
    int mism = 0;
    logic expAct;
    period = 32'hFFFF_FFFF - rl + 1;
    configure(rl, cp);
    writeReg(2'd0, {30'd0, inv, 1'b1});
    check("R2", "running after start", {31'd0, running}, 32'd1);
    for (int i = 0; i < cycles; i++) begin
      phase = i % period;
      expCount = rl + phase;
      expAct = (expCount <= cp);
      readReg(2'd3, rd);
      if (rd !== expCount || pwmOut !== (expAct ^ inv) ||
          wrapPulse !== (phase == 0 && i > 0)) begin
        mism++;
        if (mism < 4)
          $display("FAIL %s cycle %0d: count %h out %b wrap %b expected %h %b %b",
                   req, i, rd, pwmOut, wrapPulse, expCount, expAct ^ inv,
                   (phase == 0 && i > 0));
      end
      if (pwmOut == !inv) actives++;
      @(negedge clk);
    end
    nTests++;
    if (mism != 0) nFail++;
    check(req, "active cycle total", actives,
          (cp - rl + 1) * (cycles / period));
  endtask

  task automatic testReset();
    logic [31:0] rd;
    check("R1", "running", {31'd0, running}, 32'd0);
    check("R1", "pwmOut", {31'd0, pwmOut}, 32'd0);
    check("R1", "wrapPulse", {31'd0, wrapPulse}, 32'd0);
    readReg(2'd1, rd); check("R1", "reload", rd, 32'hFFFF_FFFE);
    readReg(2'd2, rd); check("R1", "compare", rd, 32'hFFFF_FFFE);
    readReg(2'd3, rd); check("R1", "count", rd, 32'd0);
    readReg(2'd0, rd); check("R10", "ctrl readback", rd, 32'd0);
  endtask

  task automatic testQuarterRate();
    // R4: 4-cycle period, 2 active (8192 Hz at 50% from 32768 Hz).
    runPattern(32'hFFFF_FFFC, 32'hFFFF_FFFD, 1'b0, 16, "R4");
  endtask

  task automatic testWritesWhileRunning();
    logic [31:0] rd;
    writeReg(2'd1, 32'hFFFF_FFF0);
    writeReg(2'd2, 32'hFFFF_FFFE);
    readReg(2'd1, rd); check("R6", "reload kept while running", rd, 32'hFFFF_FFFC);
    readReg(2'd2, rd); check("R6", "compare kept while running", rd, 32'hFFFF_FFFD);
    readReg(2'd0, rd); check("R10", "ctrl run bit", rd, 32'd1);
  endtask

  task automatic testStop();
    logic [31:0] c0, c1;
    writeReg(2'd0, 32'd0);
    check("R8", "running after stop", {31'd0, running}, 32'd0);
    check("R8", "pwmOut stopped", {31'd0, pwmOut}, 32'd0);
    readReg(2'd3, c0);
    repeat (5) @(negedge clk);
    readReg(2'd3, c1);
    check("R8", "count holds", c1, c0);
    writeReg(2'd3, 32'h1234_5678);
    readReg(2'd3, c1);
    check("R10", "count not writable", c1, c0);
  endtask

  task automatic testRejects();
    logic [31:0] rd;
    configure(32'hFFFF_FFF0, 32'hFFFF_FFF8);
    writeReg(2'd1, 32'hFFFF_FFFF);
    readReg(2'd1, rd); check("R7", "reload above max rejected", rd, 32'hFFFF_FFF0);
    writeReg(2'd1, 32'hFFFF_FFFA);
    readReg(2'd1, rd); check("R7", "reload above compare rejected", rd, 32'hFFFF_FFF0);
    writeReg(2'd2, 32'hFFFF_FFE0);
    readReg(2'd2, rd); check("R7", "compare below reload rejected", rd, 32'hFFFF_FFF8);
    writeReg(2'd2, 32'hFFFF_FFF0);
    readReg(2'd2, rd); check("R7", "compare equal reload accepted", rd, 32'hFFFF_FFF0);
  endtask

  task automatic testMinPeriod();
    runPattern(32'hFFFF_FFFE, 32'hFFFF_FFFE, 1'b0, 10, "R3");
  endtask

  task automatic testFullActive();
    runPattern(32'hFFFF_FFFB, 32'hFFFF_FFFF, 1'b0, 15, "R5");
  endtask

  task automatic testLongerPeriod();
    runPattern(32'hFFFF_FFF6, 32'hFFFF_FFF8, 1'b0, 30, "R4");
  endtask

  task automatic testInverted();
    runPattern(32'hFFFF_FFFA, 32'hFFFF_FFFB, 1'b1, 18, "R9");
    writeReg(2'd0, 32'd2);
    check("R9", "inactive level high when stopped", {31'd0, pwmOut}, 32'd1);
    writeReg(2'd0, 32'd0);
    check("R9", "active-high stopped low", {31'd0, pwmOut}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testQuarterRate();
    testWritesWhileRunning();
    testStop();
    testRejects();
    testMinPeriod();
    testFullActive();
    testLongerPeriod();
    testInverted();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule